// File: doc/BRIEF.md
# Host Port Read-Ahead Controller

This block connects a host bus to the request port of a local memory. The host side has a select, separate read and write strobes, an address, write and read data, and a ready flag. The block keeps one buffered word together with its address tag and a valid bit. A host read that matches the tag completes in the same cycle its strobe arrives. A host read that misses holds ready low until a local read has filled the buffer.

Host requests are evaluated once per four-phase machine cycle, in the last phase, so every local cycle begins on the first phase of the next machine cycle. Local cycles use a request/acknowledge handshake. A mode input picks the speculative policy. In sequential mode, the end of a host read triggers a read of the next word. In read/modify/write mode, the end of a host write triggers a read of the word just written. With no mode selected, nothing is fetched ahead, and every host read goes to memory.

Top module: `hpf_ctrl`

## Requirements
- R1: `phase_o` reads 0 in reset and advances by one each clock, 0,1,2,3,0,... Value 0 is the first phase and value 3 is the last.
- R2: Host requests are examined only while `phase_o` is 3. Because of this, `mem_req_o` rises only in a cycle where `phase_o` is 0.
- R3: Once `mem_req_o` is high, it stays high with `mem_addr_o` and `mem_we_o` unchanged until the cycle in which `mem_ack_i` is seen. Read data is taken into the buffer on that acknowledge.
- R4: A host read (`host_cs_n_i`=0, `host_rd_n_i`=0) whose address is not buffered keeps `host_rdy_o` low until the local read returns. After that, `host_rdy_o` is high and `host_rdata_o` carries the memory word.
- R5: The host address is captured in the cycle where `host_cs_n_i` falls. If the buffer is valid and its tag equals that address, `host_rdy_o` is high in that same cycle with the buffered word.
- R6: With `mode_i`=1 (sequential), ending a host read by raising either the read strobe or the select starts a local read of address+1, modulo 2^AW. A following read of that address then completes with no wait.
- R7: With `mode_i`=2 (read/modify/write), ending a host write starts a local read of the written address. The end of a host read starts no local cycle in this mode.
- R8: A host write to the buffered address invalidates the buffer. The next read of that address goes to memory and returns the written data.
- R9: With `mode_i`=0 or 3, no local read is issued except on behalf of an active host read. A repeated read of the same address goes to memory again.
- R10: A host write raises `host_rdy_o` only after its local write is acknowledged. `host_rdy_o` is never high while `host_cs_n_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | 0/3 none, 1 sequential, 2 read/modify/write |
| host_cs_n_i | input | 1 | Host select, active low |
| host_rd_n_i | input | 1 | Host read strobe, active low |
| host_wr_n_i | input | 1 | Host write strobe, active low |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Buffered read data |
| host_rdy_o | output | 1 | Host access may complete |
| phase_o | output | 2 | Machine-cycle phase |
| mem_req_o | output | 1 | Local cycle request |
| mem_we_o | output | 1 | Local cycle is a write |
| mem_addr_o | output | AW | Local cycle address |
| mem_wdata_o | output | DW | Local write data |
| mem_ack_i | input | 1 | Local cycle done |
| mem_rdata_i | input | DW | Local read data |

## Verification
A stale valid bit or a wrong tag appears at the ports on the very next host read. It shows as ready raised at once with the wrong word, or as an unexpected wait that takes several machine cycles. A lost pending-read flag does not cause an error, only a loss of speed. It is caught by counting the local reads the memory model serves after a strobe ends, and by checking the address of the last one. A phase counter or launch gate that is off by one shows up within one machine cycle, as a request that rises outside the first phase.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
    localparam int PHW = 2;

    typedef enum logic [PHW-1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_SEQ  = 2'd1,
        MODE_RMW  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;
endpackage

// File: rtl/hpf_phase.sv
module hpf_phase
    import hpf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    output logic [PHW-1:0] phase_o,
    output logic           last_o
);
    typedef struct packed {
        logic [PHW-1:0] ph;
    } ph_t;

    ph_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.ph = r_q.ph + {{(PHW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign phase_o = r_q.ph;
    assign last_o  = (r_q.ph == PH_Q4);
endmodule

// File: rtl/hpf_pfbuf.sv
module hpf_pfbuf #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] tag_i,
    input  logic [DW-1:0] data_i,
    input  logic          inv_i,
    input  logic [AW-1:0] cmp_addr_i,
    output logic          hit_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] tag;
        logic [DW-1:0] dat;
    } buf_t;

    buf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.vld = 1'b1;
            r_d.tag = tag_i;
            r_d.dat = data_i;
        end else if (inv_i) begin
            r_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hit_o   = r_q.vld && (r_q.tag == cmp_addr_i);
    assign valid_o = r_q.vld;
    assign data_o  = r_q.dat;
endmodule

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
    import hpf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          host_cs_n_i,
    input  logic          host_rd_n_i,
    input  logic          host_wr_n_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    output logic          host_rdy_o,
    output logic [1:0]    phase_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        state_e        st;
        logic          req;
        logic          we;
        logic [AW-1:0] maddr;
        logic [DW-1:0] mwdata;
        logic          cs_prev;
        logic          rd_prev;
        logic          wr_prev;
        logic          wdone;
        logic          pf_pend;
        logic [AW-1:0] addr;
        logic [AW-1:0] rd_addr;
        logic [AW-1:0] wr_addr;
        logic [AW-1:0] pf_addr;
    } ctl_t;

    ctl_t r_q, r_d;

    logic           last_ph;
    logic [PHW-1:0] ph;
    logic           hit, bvalid;
    logic [DW-1:0]  bdata;
    logic           b_load, b_inv;
    logic [AW-1:0]  eff_addr;
    logic           rd_act, wr_act, cs_fall;
    logic           m_seq, m_rmw, m_off;
    logic           rd_need, wr_need;

    hpf_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (ph),
        .last_o  (last_ph)
    );

    hpf_pfbuf #(.AW(AW), .DW(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (b_load),
        .tag_i      (r_q.maddr),
        .data_i     (mem_rdata_i),
        .inv_i      (b_inv),
        .cmp_addr_i (eff_addr),
        .hit_o      (hit),
        .valid_o    (bvalid),
        .data_o     (bdata)
    );

    always_comb begin
        rd_act   = !host_cs_n_i && !host_rd_n_i;
        wr_act   = !host_cs_n_i && !host_wr_n_i;
        cs_fall  = r_q.cs_prev && !host_cs_n_i;
        eff_addr = cs_fall ? host_addr_i : r_q.addr;
        m_seq    = (mode_i == MODE_SEQ);
        m_rmw    = (mode_i == MODE_RMW);
        m_off    = !m_seq && !m_rmw;
        rd_need  = rd_act && !hit;
        wr_need  = wr_act && !r_q.wdone;
    end

    always_comb begin
        r_d     = r_q;
        b_load  = 1'b0;
        b_inv   = (m_off && !rd_act) || (rd_act && !hit && bvalid);

        r_d.cs_prev = host_cs_n_i;
        r_d.rd_prev = rd_act;
        r_d.wr_prev = wr_act;
        if (cs_fall) r_d.addr    = host_addr_i;
        if (rd_act)  r_d.rd_addr = eff_addr;
        if (wr_act)  r_d.wr_addr = eff_addr;
        if (!wr_act) r_d.wdone   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (last_ph) begin
                    if (wr_need) begin
                        r_d.st     = ST_BUSY;
                        r_d.req    = 1'b1;
                        r_d.we     = 1'b1;
                        r_d.maddr  = eff_addr;
                        r_d.mwdata = host_wdata_i;
                        if (hit) b_inv = 1'b1;
                    end else if (rd_need) begin
                        r_d.st    = ST_BUSY;
                        r_d.req   = 1'b1;
                        r_d.we    = 1'b0;
                        r_d.maddr = eff_addr;
                    end else if (r_q.pf_pend && !m_off) begin
                        r_d.st      = ST_BUSY;
                        r_d.req     = 1'b1;
                        r_d.we      = 1'b0;
                        r_d.maddr   = r_q.pf_addr;
                        r_d.pf_pend = 1'b0;
                    end
                end
            end
            ST_BUSY: begin
                if (mem_ack_i) begin
                    r_d.st  = ST_IDLE;
                    r_d.req = 1'b0;
                    if (r_q.we) r_d.wdone = 1'b1;
                    else        b_load    = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (m_seq && r_q.rd_prev && !rd_act) begin
            r_d.pf_pend = 1'b1;
            r_d.pf_addr = r_q.rd_addr + STEP;
        end
        if (m_rmw && r_q.wr_prev && !wr_act) begin
            r_d.pf_pend = 1'b1;
            r_d.pf_addr = r_q.wr_addr;
        end
        if (m_off) r_d.pf_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.cs_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdy_o   = (rd_act && hit) || (wr_act && r_q.wdone);
    assign host_rdata_o = bdata;
    assign phase_o      = ph;
    assign mem_req_o    = r_q.req;
    assign mem_we_o     = r_q.we;
    assign mem_addr_o   = r_q.maddr;
    assign mem_wdata_o  = r_q.mwdata;
endmodule

// File: rtl/hpf_ctrl_chk.sv
module hpf_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          host_cs_n_i,
    input logic          host_rd_n_i,
    input logic          host_rdy_o,
    input logic [1:0]    phase_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ack_i
);
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd0));

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd3) |=> (phase_o == $past(phase_o) + 2'd1));

    assert_launch_first_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> (phase_o == 2'd0));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_no_spec_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_o) && !mem_we_o && (mode_i == 2'd0 || mode_i == 2'd3))
            |-> (!host_cs_n_i && !host_rd_n_i));

    assert_rdy_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy_o |-> !host_cs_n_i);
endmodule

bind hpf_ctrl hpf_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .host_cs_n_i (host_cs_n_i),
    .host_rd_n_i (host_rd_n_i),
    .host_rdy_o  (host_rdy_o),
    .phase_o     (phase_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/hpf_ctrl_test.sv
`timescale 1ns/1ps
module hpf_ctrl_test;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdy;
    logic [1:0] phase;
    logic mreq, mwe, mack = 1'b0;
    logic [AW-1:0] maddr;
    logic [DW-1:0] mwdata, mrdata = '0;

    int n_chk = 0, n_fail = 0;
    int n_reads = 0, r2_bad = 0, r3_bad = 0;
    logic [AW-1:0] last_rd = '0;
    logic [DW-1:0] mdl [1 << AW];
    bit done = 1'b0;

    always #2 clk = ~clk;

    hpf_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .host_cs_n_i(cs_n), .host_rd_n_i(rd_n), .host_wr_n_i(wr_n),
        .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdata_o(rdata), .host_rdy_o(rdy), .phase_o(phase),
        .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
        .mem_wdata_o(mwdata), .mem_ack_i(mack), .mem_rdata_i(mrdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // memory model: acknowledges after two cycles of request
    initial begin
        int lat = 0;
        logic prev_req = 1'b0;
        logic [AW-1:0] prev_addr = '0;
        for (int i = 0; i < (1 << AW); i++) mdl[i] = 16'hA000 + 16'(i);
        forever begin
            @(negedge clk);
            if (mreq && !prev_req && phase != 2'd0) r2_bad++;
            if (mreq && prev_req && !mack && maddr != prev_addr) r3_bad++;
            prev_req  = mreq;
            prev_addr = maddr;
            if (mack) begin
                mack = 1'b0;
                lat  = 0;
            end else if (mreq) begin
                lat++;
                if (lat >= 2) begin
                    mack = 1'b1;
                    if (mwe) mdl[maddr] = mwdata;
                    else begin
                        mrdata  = mdl[maddr];
                        n_reads++;
                        last_rd = maddr;
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    task automatic host_op(input logic [1:0] md, input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, output logic imm,
                           output logic [DW-1:0] got, output int wt);
        @(negedge clk);
        mode = md;
        repeat (2) @(negedge clk);
        cs_n = 1'b0; addr = a; wdata = wd;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        #1;
        imm = rdy;
        wt  = 0;
        while (!rdy && wt < 64) begin
            @(negedge clk); #1; wt++;
        end
        got = rdata;
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        check(rdy == 1'b0, "R10 ready with select high", int'(rdy), 0);
        repeat (16) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]    md;
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        logic [DW-1:0] ed;
        logic          imm;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 8'h10, 16'h0000, 16'hA010, 1'b0}, // R4 miss, no mode
        '{2'd0, 1'b0, 8'h10, 16'h0000, 16'hA010, 1'b0}, // R9 repeat goes to memory
        '{2'd1, 1'b0, 8'h20, 16'h0000, 16'hA020, 1'b0}, // R4 miss, sequential
        '{2'd1, 1'b0, 8'h21, 16'h0000, 16'hA021, 1'b1}, // R6 R5 read-ahead hit
        '{2'd1, 1'b0, 8'h22, 16'h0000, 16'hA022, 1'b1}, // R6 again
        '{2'd1, 1'b0, 8'h40, 16'h0000, 16'hA040, 1'b0}, // R5 tag mismatch
        '{2'd1, 1'b1, 8'h41, 16'h5555, 16'h0000, 1'b0}, // R8 write onto buffered word
        '{2'd1, 1'b0, 8'h41, 16'h0000, 16'h5555, 1'b0}, // R8 must miss, new data
        '{2'd2, 1'b1, 8'h50, 16'h1234, 16'h0000, 1'b0}, // R10 write waits for ack
        '{2'd2, 1'b0, 8'h50, 16'h0000, 16'h1234, 1'b1}, // R7 read after write hits
        '{2'd2, 1'b0, 8'h51, 16'h0000, 16'hA051, 1'b0}, // R7 no sequential read-ahead
        '{2'd0, 1'b0, 8'h51, 16'h0000, 16'hA051, 1'b0}, // R9 buffer dropped in none mode
        '{2'd1, 1'b0, 8'hFF, 16'h0000, 16'hA0FF, 1'b0}, // R6 wrap source
        '{2'd1, 1'b0, 8'h00, 16'h0000, 16'hA000, 1'b1}  // R6 wraps to zero
    };

    initial begin
        logic imm;
        logic [DW-1:0] got;
        int wt, base;

        // reset state, R1
        repeat (3) @(negedge clk);
        #1;
        check(phase == 2'd0, "R1 phase in reset", int'(phase), 0);
        check(mreq == 1'b0, "R3 request in reset", int'(mreq), 0);
        check(rdy == 1'b0, "R4 ready in reset", int'(rdy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); #1;
            check(phase == 2'(k), "R1 phase sequence", int'(phase), k % 4);
        end

        for (int v = 0; v < NV; v++) begin
            host_op(VEC[v].md, VEC[v].wr, VEC[v].a, VEC[v].wd, imm, got, wt);
            if (VEC[v].imm)
                check(imm == 1'b1, "R5 ready at once on hit", int'(imm), 1);
            else
                check(imm == 1'b0, "R4 ready held low on miss", int'(imm), 0);
            check(wt < 64, "R4 R10 access completes", wt, 0);
            if (!VEC[v].wr)
                check(got == VEC[v].ed, "R4 read data", int'(got), int'(VEC[v].ed));
        end

        // R6: one extra read of the next address after a sequential-mode read
        base = n_reads;
        host_op(2'd1, 1'b0, 8'h80, 16'h0, imm, got, wt);
        check(n_reads - base == 2, "R6 read count", n_reads - base, 2);
        check(last_rd == 8'h81, "R6 read-ahead address", int'(last_rd), 'h81);

        // R9: nothing speculative in none mode
        base = n_reads;
        host_op(2'd0, 1'b0, 8'h90, 16'h0, imm, got, wt);
        check(n_reads - base == 1, "R9 read count", n_reads - base, 1);
        base = n_reads;
        host_op(2'd3, 1'b0, 8'h91, 16'h0, imm, got, wt);
        check(n_reads - base == 1, "R9 mode 3 read count", n_reads - base, 1);

        // R7: read in rmw mode starts nothing, write starts a read of same address
        base = n_reads;
        host_op(2'd2, 1'b0, 8'h95, 16'h0, imm, got, wt);
        check(n_reads - base == 1, "R7 read count after read", n_reads - base, 1);
        base = n_reads;
        host_op(2'd2, 1'b1, 8'h96, 16'hBEEF, imm, got, wt);
        check(n_reads - base == 1, "R7 read count after write", n_reads - base, 1);
        check(last_rd == 8'h96, "R7 read-ahead address", int'(last_rd), 'h96);
        check(mdl[8'h96] == 16'hBEEF, "R10 write reached memory", int'(mdl[8'h96]), 'hBEEF);

        check(r2_bad == 0, "R2 launches outside first phase", r2_bad, 0);
        check(r3_bad == 0, "R3 address changed under request", r3_bad, 0);
        summary();
    end
endmodule